// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is a 16-bit timer that counts up from zero to a programmable ceiling and then back down to zero, again and again. Two compare channels watch the count and drive PWM outputs whose pulses are centred on the bottom of each cycle. The pulses stay symmetric because every compare value and the ceiling are held in a shadow register. A new value moves into the active register only when the counter lands on zero.

The ceiling comes from one of two places. It can be a dedicated ceiling register. It can also be channel A's active compare value, so that the period can be changed safely while running; in that case channel A gives up its PWM output. A prescaler chooses how often the counter steps. Single-cycle flags report compare matches and each return to zero.

Top module: `pfcPwmTimer`

## Requirements
- R1: `prescSel` sets the step rate of the counter: 1 steps on every clock, 2 every 8 clocks, 3 every 64, 4 every 256 and 5 every 1024. The values 0, 6 and 7 stop the counter, and no flag pulses while it is stopped.
- R2: With a ceiling T greater than 0, the count runs 0,1,…,T,T-1,…,1,0 and the count changes by at most one per step. One full cycle therefore lasts 2·N·T clocks, where N is the prescaler ratio. With T = 0 the counter stays at zero.
- R3: `bottomFlag` is high for one clock, in the first clock in which the counter holds zero after a step. When the ceiling is 0, this happens on every step.
- R4: A write to a compare register goes into a shadow register. The active value is updated only on the step that brings the counter to zero. If a write happens on that same clock, the newly written value is the one taken.
- R5: A write to the ceiling register is held in the same way and takes effect only at zero. `topSrc` = 0 uses the dedicated ceiling register, and `topSrc` = 1 uses channel A's active compare value.
- R6: While `topSrc` = 1, `pwmA` stays low in every mode.
- R7: `matchA` / `matchB` go high for one clock after each step on which the count equals that channel's active compare value. That gives two pulses per cycle for a value strictly between 0 and the ceiling.
- R8: Mode 2'b10 drives the PWM output low after a match while counting up, and high after a match while counting down. It is therefore high for 2·N·C clocks of each cycle, where C is the compare value. Mode 2'b11 drives the inverse level.
- R9: In mode 2'b10, a compare value of 0 keeps the output low for the whole cycle, and a compare value equal to the ceiling keeps it high. Mode 2'b11 gives the opposite levels.
- R10: Modes 2'b00 and 2'b01 hold the PWM output low.
- R11: A change of `prescSel` restarts the prescaler, so no step happens on that clock. The first step at the new rate comes N clocks later.
- R12: Synchronous reset `rst` clears the counter, all registers, the output levels and the flags. It also sets the direction to counting up.
- R13: A compare value above the active ceiling never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prescSel | input | 3 | Step-rate select (0/6/7 stop) |
| topSrc | input | 1 | Ceiling source: 0 dedicated register, 1 channel A compare |
| topWrEn | input | 1 | Write strobe for the ceiling shadow |
| topWrData | input | 16 | Ceiling write value |
| cmpAWrEn | input | 1 | Write strobe for channel A shadow |
| cmpAWrData | input | 16 | Channel A compare write value |
| cmpBWrEn | input | 1 | Write strobe for channel B shadow |
| cmpBWrData | input | 16 | Channel B compare write value |
| modeA | input | 2 | Channel A output mode |
| modeB | input | 2 | Channel B output mode |
| pwmA | output | 1 | Channel A PWM output |
| pwmB | output | 1 | Channel B PWM output |
| matchA | output | 1 | Channel A compare-match pulse |
| matchB | output | 1 | Channel B compare-match pulse |
| bottomFlag | output | 1 | Pulse on arrival at zero |

## Verification
Five step ratios are applied to one ceiling. The cycle length measured between bottom pulses then separates a wrong prescaler ratio from a wrong count sequence. Compare values are tried in the middle of the range, at zero, at the ceiling and above the ceiling. Counting high clocks and match pulses per cycle shows whether the set and clear directions, the extreme levels and the no-match case are each right. Compare values and the ceiling are rewritten in the middle of a cycle, which shows whether the shadow loads wait for zero. Switching the ceiling source shows whether channel A's value really sets the period.

// File: rtl/pfcPwmPkg.sv
package pfcPwmPkg;

  localparam int PS_W  = 10;
  localparam int DIV_W = PS_W + 1;

  typedef struct packed {
    logic tick;
    logic stepUp;
    logic stepDown;
    logic loadAct;
    logic countingUp;
  } ctrlStrobe_t;

  function automatic logic [DIV_W-1:0] prescDivide(input logic [2:0] sel);
    case (sel)
      3'd1:    prescDivide = DIV_W'(1);
      3'd2:    prescDivide = DIV_W'(8);
      3'd3:    prescDivide = DIV_W'(64);
      3'd4:    prescDivide = DIV_W'(256);
      3'd5:    prescDivide = DIV_W'(1024);
      default: prescDivide = '0;
    endcase
  endfunction

endpackage

// File: rtl/pfcPwmCtrl.sv
module pfcPwmCtrl
  import pfcPwmPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       prescSel,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] topAct,
  output ctrlStrobe_t      strobe
);

  logic [PS_W-1:0]  psCnt;
  logic [2:0]       prevSel;
  logic [DIV_W-1:0] divVal;
  logic             selSame;
  logic             tick;
  logic             up;
  logic             upNext;

  assign divVal  = prescDivide(prescSel);
  assign selSame = (prescSel == prevSel);
  assign tick    = (divVal != '0) && selSame && ({1'b0, psCnt} == divVal - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      psCnt   <= '0;
      prevSel <= '0;
    end else begin
      prevSel <= prescSel;
      if (!selSame || divVal == '0 || tick) psCnt <= '0;
      else                                  psCnt <= psCnt + PS_W'(1);
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.tick       = tick;
    strobe.countingUp = up;
    upNext            = up;
    if (tick) begin
      if (up && cnt < topAct) begin
        strobe.stepUp = 1'b1;
      end else if (cnt != '0) begin
        strobe.stepDown = 1'b1;
        upNext          = (cnt == CNT_W'(1));
        strobe.loadAct  = (cnt == CNT_W'(1));
      end else begin
        upNext         = 1'b1;
        strobe.loadAct = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) up <= 1'b1;
    else     up <= upNext;
  end

endmodule

// File: rtl/pfcPwmData.sv
module pfcPwmData
  import pfcPwmPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobe_t                strobe,
  input  logic                       topSrc,
  input  logic                       topWrEn,
  input  logic [CNT_W-1:0]           topWrData,
  input  logic [NCH-1:0]             cmpWrEn,
  input  logic [NCH-1:0][CNT_W-1:0]  cmpWrData,
  input  logic [NCH-1:0][1:0]        mode,
  output logic [CNT_W-1:0]           cnt,
  output logic [CNT_W-1:0]           topAct,
  output logic [NCH-1:0][CNT_W-1:0]  cmpAct,
  output logic [NCH-1:0]             pwm,
  output logic [NCH-1:0]             match,
  output logic                       bottomFlag
);

  logic [CNT_W-1:0] topShadow;
  logic [CNT_W-1:0] topReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      topShadow  <= '0;
      topReg     <= '0;
      bottomFlag <= 1'b0;
    end else begin
      if (strobe.stepUp)        cnt <= cnt + CNT_W'(1);
      else if (strobe.stepDown) cnt <= cnt - CNT_W'(1);
      if (topWrEn) topShadow <= topWrData;
      if (strobe.loadAct) topReg <= topWrEn ? topWrData : topShadow;
      bottomFlag <= strobe.loadAct;
    end
  end

  assign topAct = topSrc ? cmpAct[0] : topReg;

  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    logic [CNT_W-1:0] shadow;
    logic [CNT_W-1:0] active;
    logic             level;
    logic             hit;
    logic             matchQ;

    assign hit = strobe.tick && (cnt == active);

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow <= '0;
        active <= '0;
        level  <= 1'b0;
        matchQ <= 1'b0;
      end else begin
        if (cmpWrEn[ch]) shadow <= cmpWrData[ch];
        if (strobe.loadAct) active <= cmpWrEn[ch] ? cmpWrData[ch] : shadow;
        matchQ <= hit;
        if (hit) begin
          if (cnt == '0)                                 level <= 1'b0;
          else if (strobe.countingUp && cnt != topAct)   level <= 1'b0;
          else                                           level <= 1'b1;
        end
      end
    end

    logic driven;
    always_comb begin
      case (mode[ch])
        2'b10:   driven = level;
        2'b11:   driven = ~level;
        default: driven = 1'b0;
      endcase
    end

    if (ch == 0) begin : gTopShare
      assign pwm[ch] = topSrc ? 1'b0 : driven;
    end else begin : gPlain
      assign pwm[ch] = driven;
    end

    assign cmpAct[ch] = active;
    assign match[ch]  = matchQ;
  end

endmodule

// File: rtl/pfcPwmTimer.sv
module pfcPwmTimer
  import pfcPwmPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       prescSel,
  input  logic             topSrc,
  input  logic             topWrEn,
  input  logic [CNT_W-1:0] topWrData,
  input  logic             cmpAWrEn,
  input  logic [CNT_W-1:0] cmpAWrData,
  input  logic             cmpBWrEn,
  input  logic [CNT_W-1:0] cmpBWrData,
  input  logic [1:0]       modeA,
  input  logic [1:0]       modeB,
  output logic             pwmA,
  output logic             pwmB,
  output logic             matchA,
  output logic             matchB,
  output logic             bottomFlag
);

  localparam int NCH = 2;

  ctrlStrobe_t              strobe;
  logic [CNT_W-1:0]         cnt;
  logic [CNT_W-1:0]         topAct;
  logic [NCH-1:0][CNT_W-1:0] cmpAct;
  logic [NCH-1:0]           pwmVec;
  logic [NCH-1:0]           matchVec;
  logic [CNT_W-1:0]         cmpBAct;

  pfcPwmCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .prescSel (prescSel),
    .cnt      (cnt),
    .topAct   (topAct),
    .strobe   (strobe)
  );

  pfcPwmData #(.CNT_W(CNT_W), .NCH(NCH)) uData (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .topSrc     (topSrc),
    .topWrEn    (topWrEn),
    .topWrData  (topWrData),
    .cmpWrEn    ({cmpBWrEn, cmpAWrEn}),
    .cmpWrData  ({cmpBWrData, cmpAWrData}),
    .mode       ({modeB, modeA}),
    .cnt        (cnt),
    .topAct     (topAct),
    .cmpAct     (cmpAct),
    .pwm        (pwmVec),
    .match      (matchVec),
    .bottomFlag (bottomFlag)
  );

  assign cmpBAct = cmpAct[1];
  assign pwmA    = pwmVec[0];
  assign pwmB    = pwmVec[1];
  assign matchA  = matchVec[0];
  assign matchB  = matchVec[1];

endmodule

// File: rtl/pfcPwmChecker.sv
module pfcPwmChecker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       prescSel,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmpBAct,
  input logic             bottomFlag,
  input logic             matchB
);

  // R1: a stop selection freezes the counter
  p_stop_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (prescSel == 3'd0) |=> (cnt == $past(cnt)));

  // R2: the count moves by one at most
  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + CNT_W'(1) || cnt == $past(cnt) - CNT_W'(1)));

  // R3: the bottom pulse coincides with a zero count
  p_bottom_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    bottomFlag |-> (cnt == '0));

  // R4: the active compare value changes only with a bottom pulse
  p_load_at_bottom_r4: assert property (@(posedge clk) disable iff (rst)
    (cmpBAct != $past(cmpBAct)) |-> bottomFlag);

  // R7: a match pulse follows a step at the compare value
  p_match_value_r7: assert property (@(posedge clk) disable iff (rst)
    matchB |-> ($past(cnt) == $past(cmpBAct)));

endmodule

bind pfcPwmTimer pfcPwmChecker #(.CNT_W(CNT_W)) uChk (
  .clk        (clk),
  .rst        (rst),
  .prescSel   (prescSel),
  .cnt        (cnt),
  .cmpBAct    (cmpBAct),
  .bottomFlag (bottomFlag),
  .matchB     (matchB)
);

// File: tb/pfcPwmTimer_test.sv
module pfcPwmTimer_test;

  localparam int CLK_P = 10;
  localparam int W     = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   prescSel = '0;
  logic         topSrc = 1'b0;
  logic         topWrEn = 1'b0;
  logic [W-1:0] topWrData = '0;
  logic         cmpAWrEn = 1'b0;
  logic [W-1:0] cmpAWrData = '0;
  logic         cmpBWrEn = 1'b0;
  logic [W-1:0] cmpBWrData = '0;
  logic [1:0]   modeA = '0;
  logic [1:0]   modeB = '0;
  logic         pwmA, pwmB, matchA, matchB, bottomFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit cmpOn  = 0;

  always #(CLK_P/2) clk = ~clk;

  pfcPwmTimer uut (
    .clk(clk), .rst(rst), .prescSel(prescSel), .topSrc(topSrc),
    .topWrEn(topWrEn), .topWrData(topWrData),
    .cmpAWrEn(cmpAWrEn), .cmpAWrData(cmpAWrData),
    .cmpBWrEn(cmpBWrEn), .cmpBWrData(cmpBWrData),
    .modeA(modeA), .modeB(modeB),
    .pwmA(pwmA), .pwmB(pwmB), .matchA(matchA), .matchB(matchB),
    .bottomFlag(bottomFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mPs, mPrev, mCnt, mTopBuf, mTopAct;
  bit mUp, mBottom;
  int mCmpBuf[2];
  int mCmpAct[2];
  bit mLvl[2];
  bit mMatch[2];

  function automatic int ratioOf(input int s);
    case (s)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : refModel
    int d, top, nCnt;
    bit tk, ld;
    bit [1:0] md;
    bit [1:0] dummy;
    if (rst) begin
      mPs = 0; mPrev = 0; mCnt = 0; mUp = 1; mTopBuf = 0; mTopAct = 0; mBottom = 0;
      for (int c = 0; c < 2; c++) begin
        mCmpBuf[c] = 0; mCmpAct[c] = 0; mLvl[c] = 0; mMatch[c] = 0;
      end
    end else begin
      d  = ratioOf(int'(prescSel));
      tk = (d != 0) && (int'(prescSel) == mPrev) && (mPs == d - 1);
      if (int'(prescSel) != mPrev || d == 0 || tk) mPs = 0;
      else mPs = mPs + 1;
      mPrev = int'(prescSel);
      top = topSrc ? mCmpAct[0] : mTopAct;
      for (int c = 0; c < 2; c++) begin
        mMatch[c] = tk && (mCnt == mCmpAct[c]);
        if (mMatch[c]) mLvl[c] = (mCnt == 0) ? 0 : ((mUp && mCnt != top) ? 0 : 1);
      end
      ld = 0;
      nCnt = mCnt;
      if (tk) begin
        if (mUp && mCnt < top) nCnt = mCnt + 1;
        else if (mCnt != 0) begin
          nCnt = mCnt - 1;
          ld = (mCnt == 1);
          mUp = (mCnt == 1);
        end else begin
          mUp = 1;
          ld = 1;
        end
      end
      mBottom = ld;
      if (ld) begin
        mTopAct    = topWrEn  ? int'(topWrData)  : mTopBuf;
        mCmpAct[0] = cmpAWrEn ? int'(cmpAWrData) : mCmpBuf[0];
        mCmpAct[1] = cmpBWrEn ? int'(cmpBWrData) : mCmpBuf[1];
      end
      if (topWrEn)  mTopBuf    = int'(topWrData);
      if (cmpAWrEn) mCmpBuf[0] = int'(cmpAWrData);
      if (cmpBWrEn) mCmpBuf[1] = int'(cmpBWrData);
      mCnt = nCnt;
    end
    md = modeA;
    dummy = md;
  end

  function automatic int modelPwm(input int c);
    logic [1:0] md;
    if (c == 0 && topSrc) return 0;
    md = (c == 0) ? modeA : modeB;
    if (md == 2'b10) return int'(mLvl[c]);
    if (md == 2'b11) return int'(!mLvl[c]);
    return 0;
  endfunction

  always @(negedge clk) begin
    #(CLK_P/4);
    if (cmpOn && !rst) begin
      check("R8 pwmA vs model", int'(pwmA), modelPwm(0));
      check("R8 pwmB vs model", int'(pwmB), modelPwm(1));
      check("R7 matchA vs model", int'(matchA), int'(mMatch[0]));
      check("R7 matchB vs model", int'(matchB), int'(mMatch[1]));
      check("R3 R11 bottomFlag vs model", int'(bottomFlag), int'(mBottom));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic sampleTick();
    @(negedge clk);
    #(CLK_P/4);
  endtask

  task automatic waitBottom();
    do sampleTick(); while (!bottomFlag);
  endtask

  task automatic measure(output int len, output int hiA, output int hiB, output int mA, output int mB);
    len = 0; hiA = 0; hiB = 0; mA = 0; mB = 0;
    do begin
      sampleTick();
      len++;
      hiA += int'(pwmA); hiB += int'(pwmB);
      mA  += int'(matchA); mB += int'(matchB);
    end while (!bottomFlag);
  endtask

  task automatic writeTop(input int v);
    @(negedge clk); topWrEn = 1; topWrData = W'(v);
    @(negedge clk); topWrEn = 0;
  endtask

  task automatic writeCmpA(input int v);
    @(negedge clk); cmpAWrEn = 1; cmpAWrData = W'(v);
    @(negedge clk); cmpAWrEn = 0;
  endtask

  task automatic writeCmpB(input int v);
    @(negedge clk); cmpBWrEn = 1; cmpBWrData = W'(v);
    @(negedge clk); cmpBWrEn = 0;
  endtask

  task automatic setSel(input int s);
    @(negedge clk); prescSel = 3'(s);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    int len, hiA, hiB, mA, mB, flags, ms;
    repeat (4) @(negedge clk);
    rst = 0;
    sampleTick();
    // R12: reset state
    check("R12 pwmA after reset", int'(pwmA), 0);
    check("R12 pwmB after reset", int'(pwmB), 0);
    check("R12 flags after reset", int'(bottomFlag | matchA | matchB), 0);
    cmpOn = 1;

    modeA = 2'b10; modeB = 2'b11;
    writeTop(10); writeCmpA(3); writeCmpB(7);
    setSel(1);
    waitBottom(); waitBottom();
    measure(len, hiA, hiB, mA, mB);
    check("R2 period N=1 T=10", len, 20);
    check("R8 non-inverting high clocks", hiA, 6);
    check("R8 inverting high clocks", hiB, 6);
    check("R7 matchB pulses per cycle", mB, 2);

    for (int s = 2; s <= 5; s++) begin
      setSel(s);
      waitBottom();
      measure(len, hiA, hiB, mA, mB);
      check("R1 R2 period per ratio", len, 20 * ratioOf(s));
    end
    setSel(1);

    // R9 extremes
    modeB = 2'b10;
    writeCmpB(0);
    waitBottom(); waitBottom();
    measure(len, hiA, hiB, mA, mB);
    check("R9 compare zero stays low", hiB, 0);
    writeCmpB(10);
    waitBottom(); waitBottom();
    measure(len, hiA, hiB, mA, mB);
    check("R9 compare at ceiling stays high", hiB, 20);
    modeB = 2'b11;
    sampleTick();
    check("R9 inverted at ceiling low", int'(pwmB), 0);

    // R13 compare above ceiling
    writeCmpB(15);
    waitBottom();
    measure(len, hiA, hiB, mA, mB);
    check("R13 no match above ceiling", mB, 0);

    // R4 mid-cycle compare write waits for zero
    writeCmpB(7);
    waitBottom();
    repeat (3) sampleTick();
    @(negedge clk); cmpBWrEn = 1; cmpBWrData = W'(2);
    @(negedge clk); cmpBWrEn = 0;
    ms = 0;
    do begin sampleTick(); ms += int'(matchB); end while (!bottomFlag);
    check("R4 old compare kept until zero", ms, 2);

    // R5 mid-cycle ceiling write waits for zero
    waitBottom();
    len = 0;
    repeat (3) begin sampleTick(); len++; end
    @(negedge clk); topWrEn = 1; topWrData = W'(4);
    #(CLK_P/4); len++;
    @(negedge clk); topWrEn = 0;
    #(CLK_P/4); len++;
    while (!bottomFlag) begin sampleTick(); len++; end
    check("R5 current cycle keeps old ceiling", len, 20);
    measure(len, hiA, hiB, mA, mB);
    check("R5 next cycle uses new ceiling", len, 8);

    // R5/R6 channel A compare as ceiling
    writeCmpA(6);
    waitBottom();
    topSrc = 1;
    waitBottom();
    measure(len, hiA, hiB, mA, mB);
    check("R5 ceiling from channel A", len, 12);
    check("R6 pwmA silent while sharing", hiA, 0);
    topSrc = 0;

    // R10 disabled modes
    writeCmpB(2);
    modeB = 2'b00;
    waitBottom(); waitBottom();
    measure(len, hiA, hiB, mA, mB);
    check("R10 mode 00 low", hiB, 0);
    modeB = 2'b01;
    measure(len, hiA, hiB, mA, mB);
    check("R10 mode 01 low", hiB, 0);

    // R1 stop selections
    foreach (ms_sel[i]) ;
    for (int s = 0; s < 3; s++) begin
      setSel(s == 0 ? 0 : (s == 1 ? 6 : 7));
      flags = 0;
      repeat (300) begin sampleTick(); flags += int'(bottomFlag | matchA | matchB); end
      check("R1 stopped counter raises no flag", flags, 0);
    end

    // R11 restart at a new ratio, checked against the model
    setSel(2);
    repeat (5) sampleTick();
    setSel(3);
    setSel(2);
    repeat (400) sampleTick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int ms_sel[1];

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule